// File: doc/BRIEF.md
# Logical-AND Instruction Decode and Execute Unit

This unit takes a byte stream of variable-length machine instructions, one byte per clock while `in_valid` is high. It picks out the logical-AND encodings of a CISC instruction set and executes them against an internal file of eight 32-bit registers. For each instruction it collects the opcode byte, the operand-selector byte where the form has one, and any immediate bytes. It then reads both operands, writes the masked AND result back, and updates the status flags. A per-instruction width input picks 16-bit or 32-bit operation for the forms that are not fixed at 8 bits.

Only register operands are executed. A selector byte that names a memory operand ends the instruction with a distinct status code and leaves all state unchanged. A group opcode whose selector does not pick the AND operation also ends the instruction without effect, and so does any opcode outside the AND family. A side port preloads and reads back the registers, so the surrounding logic and the bench can seed and inspect the operand state.

Top module: `and_exec_unit`

## Requirements
- R1: After reset, all eight registers read zero, `flags` is zero, `done` is low and `status` is 0.
- R2: Opcode 0x24 ANDs the low byte of register 0 with one immediate byte. Opcode 0x25 ANDs register 0 with an immediate of the operand width: 2 bytes when `op_wide`=0, or 4 bytes when `op_wide`=1. Immediates are sent least significant byte first. `op_wide` is sampled with the opcode byte.
- R3: Opcodes 0x80 (8-bit, 1 immediate byte) and 0x81 (operand-width immediate) AND the register named by selector bits [2:0] with the immediate, but only when selector bits [5:3] equal 4.
- R4: For opcode 0x83, the single immediate byte is sign-extended to the operand width (16 or 32 bits) before the AND.
- R5: Opcodes 0x20 and 0x21 write the AND into the register named by selector bits [2:0]. Opcodes 0x22 and 0x23 write it into the register named by bits [5:3]. 0x20 and 0x22 are 8-bit; 0x21 and 0x23 use the operand width.
- R6: `flags` bit 0 (carry) and bit 5 (overflow) clear on every executed AND. Bit 3 (zero) and bit 4 (sign, the top bit of the active width) follow the result at its active width. Bit 1 (parity) is 1 when result bits [7:0] hold an even number of ones. Bit 2 is held.
- R7: An 8-bit register number n below 4 names bits [7:0] of register n, and n of 4 to 7 names bits [15:8] of register n-4. A 16-bit write leaves bits [31:16] unchanged, and an 8-bit write leaves the other bytes unchanged.
- R8: A selector byte with bits [7:6] not equal to 3 ends the instruction with `status`=1. Registers and flags stay unchanged, and the next byte is taken as an opcode.
- R9: A group opcode with selector bits [5:3] not 4, or any opcode outside the AND set, ends the instruction with `status`=2 and no register or flag change.
- R10: `done` is high for exactly the one cycle after the last byte of an instruction is accepted. In that cycle `status` holds the outcome and, when `status`=0, `result` holds the zero-extended masked result.
- R11: `ld_en` writes `ld_data` into register `ld_sel` at the clock edge, unless an instruction writes a register at that same edge, in which case the load is ignored. `rd_data` shows register `rd_sel` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte present this cycle |
| in_byte | input | 8 | Instruction byte |
| op_wide | input | 1 | Operand width for the instruction: 1 for 32-bit, 0 for 16-bit |
| ld_en | input | 1 | Register preload strobe |
| ld_sel | input | 3 | Register to preload |
| ld_data | input | 32 | Preload value |
| rd_sel | input | 3 | Register to read back |
| rd_data | output | 32 | Read-back value |
| done | output | 1 | Instruction finished, one-cycle pulse |
| status | output | 2 | 0 executed, 1 memory form, 2 illegal |
| result | output | 32 | Result of the last executed AND |
| flags | output | 6 | Status flags: carry, parity, aux, zero, sign, overflow |

## Verification
The operand width is exercised in all three sizes against register values that are reloaded at random, so a wrong mask or a wrong lane shows up in the untouched register bytes. The stimulus mixes accumulator, group and register-to-register forms, so the swapped destination of 0x20/0x21 against 0x22/0x23 is exposed by comparing every register after each instruction. Immediates with the top bit set tell sign extension on 0x83 apart from the zero-extended immediates of 0x80 and 0x81. Memory selectors, wrong group fields and foreign opcodes are mixed into the stream, which shows that faults change nothing and that decoding restarts cleanly at the next byte.

// File: rtl/andx_pkg.sv
package andx_pkg;

   typedef enum logic [1:0] {SZ8 = 2'd0, SZ16 = 2'd1, SZ32 = 2'd2} opsz_e;
   typedef enum logic [1:0] {RES_OK = 2'd0, RES_MEMFORM = 2'd1, RES_ILLEGAL = 2'd2} res_code_e;
   typedef enum logic [1:0] {TGT_ACC = 2'd0, TGT_RM = 2'd1, TGT_REG = 2'd2} tgt_e;

   localparam int FLG_CF    = 0;
   localparam int FLG_PF    = 1;
   localparam int FLG_AF    = 2;
   localparam int FLG_ZF    = 3;
   localparam int FLG_SF    = 4;
   localparam int FLG_OF    = 5;
   localparam int FLG_COUNT = 6;

   // selector byte: mode [7:6], reg [5:3], rm [2:0]
   localparam logic [2:0] GRP_AND_SEL = 3'd4;

   typedef struct packed {
      logic       legal;
      logic       has_sel;
      logic       grp;
      logic       sext8;
      logic       src_from_rm;
      tgt_e       tgt;
      opsz_e      size;
      logic [2:0] imm_len;
   } opc_info_t;

   function automatic opc_info_t decode_opc(input logic [7:0] opc, input logic wide);
      opc_info_t d;
      opsz_e     full;
      logic [2:0] full_len;
      full     = wide ? SZ32 : SZ16;
      full_len = wide ? 3'd4 : 3'd2;
      d.legal       = 1'b1;
      d.has_sel     = 1'b1;
      d.grp         = 1'b0;
      d.sext8       = 1'b0;
      d.src_from_rm = 1'b0;
      d.tgt         = TGT_RM;
      d.size        = full;
      d.imm_len     = 3'd0;
      case (opc)
         8'h20: d.size = SZ8;
         8'h21: d.size = full;
         8'h22: begin d.size = SZ8; d.tgt = TGT_REG; d.src_from_rm = 1'b1; end
         8'h23: begin d.tgt = TGT_REG; d.src_from_rm = 1'b1; end
         8'h24: begin d.size = SZ8; d.tgt = TGT_ACC; d.has_sel = 1'b0; d.imm_len = 3'd1; end
         8'h25: begin d.tgt = TGT_ACC; d.has_sel = 1'b0; d.imm_len = full_len; end
         8'h80: begin d.size = SZ8; d.grp = 1'b1; d.imm_len = 3'd1; end
         8'h81: begin d.grp = 1'b1; d.imm_len = full_len; end
         8'h83: begin d.grp = 1'b1; d.imm_len = 3'd1; d.sext8 = 1'b1; end
         default: begin d.legal = 1'b0; d.has_sel = 1'b0; end
      endcase
      return d;
   endfunction

endpackage

// File: rtl/and_insn_collector.sv
module and_insn_collector
   import andx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              op_wide,
   output logic              fire,
   output logic              fault,
   output res_code_e         fault_code,
   output opsz_e             x_size,
   output logic [2:0]        x_dst_idx,
   output logic [2:0]        x_src_idx,
   output logic              x_src_imm,
   output logic [DATA_W-1:0] x_imm
);

   typedef enum logic [1:0] {PH_OPC = 2'd0, PH_SEL = 2'd1, PH_IMM = 2'd2} phase_e;

   localparam int POS_W = $clog2(DATA_W / 8);

   phase_e            ph_q, ph_d;
   logic [7:0]        opc_q;
   logic              wide_q;
   logic [5:0]        sel_q;
   logic [DATA_W-1:0] imm_q;
   logic [2:0]        left_q, left_d;
   logic [POS_W-1:0]  pos_q;

   opc_info_t         info;
   logic [7:0]        opc_cur;
   logic              wide_cur;
   logic [5:0]        sel_cur;
   logic [DATA_W-1:0] imm_now;

   always_comb begin
      opc_cur  = (ph_q == PH_OPC) ? in_byte : opc_q;
      wide_cur = (ph_q == PH_OPC) ? op_wide : wide_q;
      sel_cur  = (ph_q == PH_SEL) ? in_byte[5:0] : sel_q;
      info     = decode_opc(opc_cur, wide_cur);
      imm_now  = imm_q | (DATA_W'(in_byte) << {pos_q, 3'b000});
   end

   always_comb begin
      ph_d       = ph_q;
      left_d     = left_q;
      fire       = 1'b0;
      fault      = 1'b0;
      fault_code = RES_OK;
      if (in_valid) begin
         case (ph_q)
            PH_OPC: begin
               if (!info.legal) begin
                  fault      = 1'b1;
                  fault_code = RES_ILLEGAL;
               end else if (info.has_sel) begin
                  ph_d = PH_SEL;
               end else begin
                  ph_d   = PH_IMM;
                  left_d = info.imm_len;
               end
            end
            PH_SEL: begin
               ph_d = PH_OPC;
               if (in_byte[7:6] != 2'b11) begin
                  fault      = 1'b1;
                  fault_code = RES_MEMFORM;
               end else if (info.grp && in_byte[5:3] != GRP_AND_SEL) begin
                  fault      = 1'b1;
                  fault_code = RES_ILLEGAL;
               end else if (info.imm_len == 3'd0) begin
                  fire = 1'b1;
               end else begin
                  ph_d   = PH_IMM;
                  left_d = info.imm_len;
               end
            end
            PH_IMM: begin
               if (left_q == 3'd1) begin
                  fire = 1'b1;
                  ph_d = PH_OPC;
               end else begin
                  left_d = left_q - 3'd1;
               end
            end
            default: ph_d = PH_OPC;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_OPC;
         opc_q  <= '0;
         wide_q <= 1'b0;
         sel_q  <= '0;
         imm_q  <= '0;
         left_q <= '0;
         pos_q  <= '0;
      end else begin
         ph_q   <= ph_d;
         left_q <= left_d;
         if (in_valid) begin
            case (ph_q)
               PH_OPC: begin
                  opc_q  <= in_byte;
                  wide_q <= op_wide;
                  sel_q  <= '0;
                  imm_q  <= '0;
                  pos_q  <= '0;
               end
               PH_SEL: sel_q <= in_byte[5:0];
               PH_IMM: begin
                  imm_q <= imm_now;
                  pos_q <= pos_q + 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      x_size    = info.size;
      x_src_imm = (info.imm_len != 3'd0);
      case (info.tgt)
         TGT_ACC: x_dst_idx = 3'd0;
         TGT_REG: x_dst_idx = sel_cur[5:3];
         default: x_dst_idx = sel_cur[2:0];
      endcase
      x_src_idx = info.src_from_rm ? sel_cur[2:0] : sel_cur[5:3];
      x_imm     = info.sext8 ? {{(DATA_W-8){imm_now[7]}}, imm_now[7:0]} : imm_now;
   end

   // R2
   imm_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_IMM) |-> (left_q != 3'd0));

   // R10
   fire_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fire, fault}));

endmodule

// File: rtl/and_regfile.sv
module and_regfile
   import andx_pkg::*;
#(
   parameter int REGS = 8,
   parameter int W    = 32,
   localparam int IDX_W = $clog2(REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_idx,
   input  opsz_e            ra_size,
   output logic [W-1:0]     ra_data,
   input  logic [IDX_W-1:0] rb_idx,
   input  opsz_e            rb_size,
   output logic [W-1:0]     rb_data,
   input  logic             we,
   input  logic [IDX_W-1:0] w_idx,
   input  opsz_e            w_size,
   input  logic [W-1:0]     w_data,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [W-1:0]     ld_data,
   input  logic [IDX_W-1:0] dbg_idx,
   output logic [W-1:0]     dbg_data
);

   logic [W-1:0]     regs_q [REGS];
   logic [IDX_W-1:0] w_base;
   logic             w_hi;

   function automatic logic [IDX_W-1:0] lane_base(input logic [IDX_W-1:0] idx, input opsz_e sz);
      return (sz == SZ8) ? {1'b0, idx[IDX_W-2:0]} : idx;
   endfunction

   function automatic logic [W-1:0] lane_pick(input logic [W-1:0] word, input logic hi, input opsz_e sz);
      case (sz)
         SZ8:     return hi ? W'(word[15:8]) : W'(word[7:0]);
         SZ16:    return W'(word[15:0]);
         default: return word;
      endcase
   endfunction

   always_comb begin
      ra_data  = lane_pick(regs_q[lane_base(ra_idx, ra_size)], ra_idx[IDX_W-1], ra_size);
      rb_data  = lane_pick(regs_q[lane_base(rb_idx, rb_size)], rb_idx[IDX_W-1], rb_size);
      dbg_data = regs_q[dbg_idx];
      w_base   = lane_base(w_idx, w_size);
      w_hi     = (w_size == SZ8) && w_idx[IDX_W-1];
   end

   for (genvar i = 0; i < REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs_q[i] <= '0;
         end else if (we && w_base == IDX_W'(i)) begin
            case (w_size)
               SZ8: begin
                  if (w_hi) regs_q[i][15:8] <= w_data[7:0];
                  else      regs_q[i][7:0]  <= w_data[7:0];
               end
               SZ16:    regs_q[i][15:0] <= w_data[15:0];
               default: regs_q[i]       <= w_data;
            endcase
         end else if (ld_en && !we && ld_idx == IDX_W'(i)) begin
            regs_q[i] <= ld_data;
         end
      end

      // R7
      hi_half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && w_base == IDX_W'(i) && w_size != SZ32) |=> $stable(regs_q[i][W-1:16]));
   end

endmodule

// File: rtl/and_logic_core.sv
module and_logic_core
   import andx_pkg::*;
#(
   parameter int W        = 32,
   parameter int PAR_BITS = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  opsz_e        size,
   output logic [W-1:0] res,
   output logic         zf,
   output logic         sf,
   output logic         pf
);

   logic [W-1:0] mask;

   always_comb begin
      case (size)
         SZ8:     mask = W'(8'hFF);
         SZ16:    mask = W'(16'hFFFF);
         default: mask = '1;
      endcase
      res = a & b & mask;
      zf  = (res == '0);
      case (size)
         SZ8:     sf = res[7];
         SZ16:    sf = res[15];
         default: sf = res[W-1];
      endcase
      pf = ~^res[PAR_BITS-1:0];
   end

endmodule

// File: rtl/and_exec_unit.sv
module and_exec_unit
   import andx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_COUNT = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   input  logic [7:0]  in_byte,
   input  logic        op_wide,
   input  logic        ld_en,
   input  logic [2:0]  ld_sel,
   input  logic [31:0] ld_data,
   input  logic [2:0]  rd_sel,
   output logic [31:0] rd_data,
   output logic        done,
   output logic [1:0]  status,
   output logic [31:0] result,
   output logic [5:0]  flags
);

   initial begin
      assert (DATA_W == 32) else $error("and_exec_unit: DATA_W must be 32");
      assert (REG_COUNT == 8) else $error("and_exec_unit: REG_COUNT must be 8");
   end

   logic              fire, fault;
   res_code_e         fault_code;
   opsz_e             x_size;
   logic [2:0]        x_dst_idx, x_src_idx;
   logic              x_src_imm;
   logic [DATA_W-1:0] x_imm;
   logic [DATA_W-1:0] opa, opb_reg, opb;
   logic [DATA_W-1:0] core_res;
   logic              core_zf, core_sf, core_pf;

   logic                 done_q;
   res_code_e            status_q;
   logic [DATA_W-1:0]    result_q;
   logic [FLG_COUNT-1:0] flags_q;

   and_insn_collector #(.DATA_W(DATA_W)) u_collect (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_byte    (in_byte),
      .op_wide    (op_wide),
      .fire       (fire),
      .fault      (fault),
      .fault_code (fault_code),
      .x_size     (x_size),
      .x_dst_idx  (x_dst_idx),
      .x_src_idx  (x_src_idx),
      .x_src_imm  (x_src_imm),
      .x_imm      (x_imm)
   );

   and_regfile #(.REGS(REG_COUNT), .W(DATA_W)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .ra_idx   (x_dst_idx),
      .ra_size  (x_size),
      .ra_data  (opa),
      .rb_idx   (x_src_idx),
      .rb_size  (x_size),
      .rb_data  (opb_reg),
      .we       (fire),
      .w_idx    (x_dst_idx),
      .w_size   (x_size),
      .w_data   (core_res),
      .ld_en    (ld_en),
      .ld_idx   (ld_sel),
      .ld_data  (ld_data),
      .dbg_idx  (rd_sel),
      .dbg_data (rd_data)
   );

   assign opb = x_src_imm ? x_imm : opb_reg;

   and_logic_core #(.W(DATA_W), .PAR_BITS(8)) u_core (
      .a    (opa),
      .b    (opb),
      .size (x_size),
      .res  (core_res),
      .zf   (core_zf),
      .sf   (core_sf),
      .pf   (core_pf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         status_q <= RES_OK;
         result_q <= '0;
         flags_q  <= '0;
      end else begin
         done_q <= fire | fault;
         if (fire) begin
            status_q        <= RES_OK;
            result_q        <= core_res;
            flags_q[FLG_CF] <= 1'b0;
            flags_q[FLG_OF] <= 1'b0;
            flags_q[FLG_ZF] <= core_zf;
            flags_q[FLG_SF] <= core_sf;
            flags_q[FLG_PF] <= core_pf;
         end else if (fault) begin
            status_q <= fault_code;
         end
      end
   end

   assign done   = done_q;
   assign status = status_q;
   assign result = result_q;
   assign flags  = flags_q;

   // R6
   cf_of_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd0) |-> (!flags[FLG_CF] && !flags[FLG_OF]));

   // R6
   zero_flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd0) |-> (flags[FLG_ZF] == (result == '0)));

   // R8
   memform_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd1) |-> $stable(flags));

   // R9
   illegal_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd2) |-> $stable(flags));

endmodule

// File: tb/sim_and_exec_unit.sv
module sim_and_exec_unit;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [7:0]  in_byte;
   logic        op_wide;
   logic        ld_en;
   logic [2:0]  ld_sel;
   logic [31:0] ld_data;
   logic [2:0]  rd_sel;
   logic [31:0] rd_data;
   logic        done;
   logic [1:0]  status;
   logic [31:0] result;
   logic [5:0]  flags;

   always #4 clk = ~clk;

   and_exec_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte), .op_wide(op_wide),
      .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .done(done), .status(status), .result(result), .flags(flags)
   );

   int vec_cnt = 0;
   int err_cnt = 0;
   bit finished = 0;

   logic [31:0] m [8];
   logic [5:0]  mflags;
   logic [7:0]  ib [6];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vec_cnt++;
      if (act !== exp) begin
         err_cnt++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mread(input logic [2:0] n, input int sz);
      if (sz == 8) return (n < 4) ? {24'd0, m[n][7:0]} : {24'd0, m[n - 4][15:8]};
      if (sz == 16) return {16'd0, m[n][15:0]};
      return m[n];
   endfunction

   task automatic mwrite(input logic [2:0] n, input int sz, input logic [31:0] v);
      if (sz == 8) begin
         if (n < 4) m[n][7:0] = v[7:0];
         else       m[n - 4][15:8] = v[7:0];
      end else if (sz == 16) m[n][15:0] = v[15:0];
      else m[n] = v;
   endtask

   task automatic predict(input logic [7:0] opc, input logic [7:0] sel, input logic [31:0] imm_in,
                          input logic w, output logic [1:0] st, output logic [31:0] res,
                          output string cat);
      int sz;
      logic [2:0]  di, si;
      logic        use_imm, grp, has_sel;
      logic [31:0] av, bv, msk, imm;
      sz = w ? 32 : 16; di = 0; si = 0; use_imm = 0; grp = 0; has_sel = 1;
      imm = imm_in; st = 2'd0; res = 0; cat = "R9";
      case (opc)
         8'h20: begin sz = 8; di = sel[2:0]; si = sel[5:3]; cat = "R5"; end
         8'h21: begin di = sel[2:0]; si = sel[5:3]; cat = "R5"; end
         8'h22: begin sz = 8; di = sel[5:3]; si = sel[2:0]; cat = "R5"; end
         8'h23: begin di = sel[5:3]; si = sel[2:0]; cat = "R5"; end
         8'h24: begin sz = 8; use_imm = 1; has_sel = 0; cat = "R2"; end
         8'h25: begin use_imm = 1; has_sel = 0; cat = "R2"; end
         8'h80: begin sz = 8; di = sel[2:0]; use_imm = 1; grp = 1; cat = "R3"; end
         8'h81: begin di = sel[2:0]; use_imm = 1; grp = 1; cat = "R3"; end
         8'h83: begin di = sel[2:0]; use_imm = 1; grp = 1; cat = "R4";
                      imm = {{24{imm_in[7]}}, imm_in[7:0]}; end
         default: begin st = 2'd2; has_sel = 0; end
      endcase
      if (st == 0 && has_sel && sel[7:6] != 2'b11) begin st = 2'd1; cat = "R8"; end
      else if (st == 0 && grp && sel[5:3] != 3'd4) begin st = 2'd2; cat = "R9"; end
      if (st == 0) begin
         msk = (sz == 8) ? 32'hFF : (sz == 16) ? 32'hFFFF : 32'hFFFF_FFFF;
         av  = mread(di, sz);
         bv  = use_imm ? imm : mread(si, sz);
         res = av & bv & msk;
         mwrite(di, sz, res);
         mflags[0] = 1'b0;
         mflags[5] = 1'b0;
         mflags[3] = (res == 0);
         mflags[4] = (sz == 8) ? res[7] : (sz == 16) ? res[15] : res[31];
         mflags[1] = ~^res[7:0];
      end
   endtask

   task automatic check_regs(input string req);
      for (int r = 0; r < 8; r++) begin
         rd_sel = 3'(r);
         #1;
         check(req, rd_data, m[r]);
      end
   endtask

   task automatic load_reg(input logic [2:0] n, input logic [31:0] v);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = n; ld_data = v;
      m[n] = v;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // sends nb bytes from ib, then checks outcome at the cycle after the last byte
   task automatic run_insn(input int nb, input logic w, input logic [7:0] sel,
                           input logic [31:0] imm, input bit clash_load);
      logic [1:0]  est;
      logic [31:0] eres;
      string       cat;
      predict(ib[0], sel, imm, w, est, eres, cat);
      for (int k = 0; k < nb; k++) begin
         @(negedge clk);
         in_valid = 1'b1; in_byte = ib[k]; op_wide = w;
         if (clash_load && k == nb - 1) begin
            ld_en = 1'b1; ld_sel = 3'd7; ld_data = 32'hDEAD_BEEF;
         end
      end
      @(negedge clk);
      in_valid = 1'b0; ld_en = 1'b0;
      check("R10 done", {31'd0, done}, 32'd1);
      check({cat, " status"}, {30'd0, status}, {30'd0, est});
      if (est == 0) check({cat, " result"}, result, eres);
      check("R6 flags", {26'd0, flags & 6'b111011}, {26'd0, mflags & 6'b111011});
      check_regs(clash_load ? "R11 clash" : cat);
      @(negedge clk);
      check("R10 pulse", {31'd0, done}, 32'd0);
   endtask

   task automatic build(input logic [7:0] opc, input logic [7:0] sel, input logic [31:0] imm,
                        input logic w, output int nb);
      int il;
      logic hs;
      hs = 1; il = 0;
      case (opc)
         8'h24: begin hs = 0; il = 1; end
         8'h25: begin hs = 0; il = w ? 4 : 2; end
         8'h80, 8'h83: il = 1;
         8'h81: il = w ? 4 : 2;
         8'h20, 8'h21, 8'h22, 8'h23: il = 0;
         default: begin hs = 0; il = 0; end
      endcase
      ib[0] = opc; nb = 1;
      if (hs) begin
         ib[1] = sel; nb = 2;
         if (sel[7:6] != 2'b11) return;
         if ((opc == 8'h80 || opc == 8'h81 || opc == 8'h83) && sel[5:3] != 3'd4) return;
      end
      for (int k = 0; k < il; k++) begin
         ib[nb] = imm[8*k +: 8];
         nb++;
      end
   endtask

   task automatic do_insn(input logic [7:0] opc, input logic [7:0] sel, input logic [31:0] imm,
                          input logic w, input bit clash);
      int nb;
      build(opc, sel, imm, w, nb);
      run_insn(nb, w, sel, imm, clash);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         err_cnt++;
         vec_cnt++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
         $finish;
      end
   end

   initial begin
      logic [7:0] ops [9];
      ops = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h80, 8'h81, 8'h83};
      void'($urandom(32'h5EED_0123));
      rst_n = 1'b0; in_valid = 1'b0; in_byte = 0; op_wide = 0;
      ld_en = 0; ld_sel = 0; ld_data = 0; rd_sel = 0;
      for (int r = 0; r < 8; r++) m[r] = 0;
      mflags = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 done", {31'd0, done}, 32'd0);
      check("R1 status", {30'd0, status}, 32'd0);
      check("R1 flags", {26'd0, flags}, 32'd0);
      check_regs("R1 regs");

      // R11 preload and readback
      for (int r = 0; r < 8; r++) load_reg(3'(r), 32'h1111_1111 * (r + 1) ^ 32'hA5C3_96F0);
      check_regs("R11 load");

      // directed corners
      load_reg(3'd0, 32'h1234_56F8);
      do_insn(8'h24, 8'h00, 32'h0000_008F, 1'b0, 0);      // R2 8-bit accumulator
      load_reg(3'd0, 32'hCAFE_F00D);
      do_insn(8'h25, 8'h00, 32'h0000_8F0F, 1'b0, 0);      // R2 16-bit, upper kept (R7)
      do_insn(8'h25, 8'h00, 32'h0000_0000, 1'b1, 0);      // R6 zero result
      load_reg(3'd2, 32'h8765_4321);
      do_insn(8'h83, 8'hE2, 32'h0000_00F0, 1'b1, 0);      // R4 negative imm, 32-bit
      load_reg(3'd3, 32'hFFFF_FFFF);
      do_insn(8'h83, 8'hE3, 32'h0000_0080, 1'b0, 0);      // R4 16-bit sign extend
      load_reg(3'd1, 32'h0000_3C00);
      load_reg(3'd0, 32'h0000_F0FF);
      do_insn(8'h20, 8'hE5, 32'h0, 1'b0, 0);              // R7 high byte reg1 &= high byte reg0
      do_insn(8'h22, 8'hE1, 32'h0, 1'b0, 0);              // R5 reg field destination (R7 lane)
      do_insn(8'h21, 8'h0A, 32'h0, 1'b1, 0);              // R8 memory form
      do_insn(8'h81, 8'hC8, 32'h0, 1'b1, 0);              // R9 wrong group field
      do_insn(8'h30, 8'h00, 32'h0, 1'b1, 0);              // R9 foreign opcode
      do_insn(8'h80, 8'hE6, 32'h0000_00FF, 1'b0, 0);      // R3 after faults, decode restarted
      do_insn(8'h23, 8'hC6, 32'h0, 1'b1, 1);              // R11 load ignored during exec

      // constrained random
      for (int t = 0; t < 400; t++) begin
         logic [7:0]  opc, sel;
         logic [31:0] imm;
         logic        w;
         if (t % 5 == 0)
            for (int r = 0; r < 8; r++) load_reg(3'(r), $urandom | $urandom);
         opc = ($urandom % 20 == 0) ? 8'($urandom % 16 + 8'h40) : ops[$urandom % 9];
         sel[7:6] = ($urandom % 8 == 0) ? 2'($urandom % 3) : 2'b11;
         sel[5:3] = ((opc == 8'h80 || opc == 8'h81 || opc == 8'h83) && ($urandom % 8 != 0))
                    ? 3'd4 : 3'($urandom);
         sel[2:0] = 3'($urandom);
         imm = $urandom;
         w = 1'($urandom);
         do_insn(opc, sel, imm, w, 0);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
   end

endmodule